// File: doc/BRIEF.md
# Program Status Register Write Unit

This unit holds the live processor status word and one saved copy for each exception bank. A move-to-status instruction updates either the live word or the saved copy of the current bank. The caller supplies a four-bit field mask, where each bit enables one byte. For the live word, the three low bytes can only be written in a privileged mode, so software in user mode can change only the condition flags.

The individual flags, the mode and a privileged indication come straight from the live register. Any update to the five mode bits raises a one-cycle mode-switch pulse toward the register file, so that it can swap its banked registers. A separate mode request input forces a new mode directly and takes precedence over a status write in the same cycle.

Saved copies are read through their own mode selector. Selecting a mode that has no saved copy returns the live word instead.

Top module: `psr_write_unit`

## Requirements
- R1: After reset the live word is 0x000000D3: supervisor mode 5'b10011, I and F set, all other bits clear. Every saved copy reads 0 and `mode_switch` is low.
- R2: A live-word write (`wr_target`=0) made in a privileged mode replaces byte k (bits 8k+7..8k) with the same byte of `wr_data` exactly when `field_mask[k]` is set. All other bytes keep their value.
- R3: In a user mode (mode bits [1:0] = 00), a live-word write updates only byte 3, under `field_mask[3]`. Bytes 0 to 2 are unchanged.
- R4: A saved-copy write (`wr_target`=1) updates the saved copy of the current bank under all four mask bits, with no privilege filter, and leaves the live word unchanged. The banks are fiq 10001, irq 10010, svc 10011, abort 10111 and undef 11011, and each has its own copy.
- R5: A saved-copy write issued in a mode with no bank (user 10000, system 11111 or any other encoding) changes no saved copy.
- R6: `spsr_out` shows the saved copy of the bank selected by `rd_mode`. When `rd_mode` selects no bank, it shows the live word.
- R7: The flag outputs map to these bits of the live word: N bit 31, Z bit 30, C bit 29, V bit 28, I bit 7, F bit 6, T bit 5. `mode_out` is bits 4..0.
- R8: `mode_switch` is high for exactly the one cycle after an accepted update that changed the mode bits. It stays low when the mode bits are unchanged.
- R9: `privileged` is high exactly when either of the two low mode bits is 1.
- R10: `mode_req` loads `mode_req_val` into the mode bits with no privilege check. In the same cycle it cancels any `wr_en` write, both live and saved.
- R11: Updates appear on the outputs in the cycle after the clock edge that accepts them. With no request, the live word holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Status write request |
| wr_target | input | 1 | 0 selects the live word, 1 selects the current bank's saved copy |
| field_mask | input | 4 | Byte enables, bit k enables byte k |
| wr_data | input | 32 | Value to write |
| mode_req | input | 1 | Force a mode change |
| mode_req_val | input | 5 | Mode to force |
| rd_mode | input | 5 | Mode whose saved copy is read |
| cpsr_out | output | 32 | Live status word |
| spsr_out | output | 32 | Selected saved copy, or the live word |
| mode_out | output | 5 | Current mode |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry flag |
| flag_v | output | 1 | Overflow flag |
| flag_i | output | 1 | IRQ disable |
| flag_f | output | 1 | FIQ disable |
| flag_t | output | 1 | Compact instruction state |
| mode_switch | output | 1 | One-cycle pulse after a mode change |
| privileged | output | 1 | Current mode is privileged |

## Verification
The assertions check four things on every cycle:
- A user-mode live write never touches the low three bytes.
- A saved write or an idle cycle leaves the live word unchanged.
- The mode-switch pulse agrees with a real change of the mode bits.
- A mode request always lands.

Some behaviours need the bench's scenarios and its model of the live word and the five saved copies:
- the byte-to-mask mapping under every mask value;
- the separation between banks;
- dropping saved writes in unbanked modes;
- falling back to the live word on reads.

// File: rtl/psr_pkg.sv
package psr_pkg;

   localparam int PSR_W     = 32;
   localparam int MODE_W    = 5;
   localparam int BYTE_W    = 8;
   localparam int FIELDS    = PSR_W / BYTE_W;
   localparam int BANKS     = 5;
   localparam int BANK_IDX_W = 3;

   localparam logic [MODE_W-1:0] MODE_USR = 5'b10000;
   localparam logic [MODE_W-1:0] MODE_FIQ = 5'b10001;
   localparam logic [MODE_W-1:0] MODE_IRQ = 5'b10010;
   localparam logic [MODE_W-1:0] MODE_SVC = 5'b10011;
   localparam logic [MODE_W-1:0] MODE_ABT = 5'b10111;
   localparam logic [MODE_W-1:0] MODE_UND = 5'b11011;
   localparam logic [MODE_W-1:0] MODE_SYS = 5'b11111;

   localparam logic [PSR_W-1:0] PSR_RESET = 32'h0000_00D3;

   typedef struct packed {
      logic                  valid;
      logic [BANK_IDX_W-1:0] idx;
   } bank_sel_t;

   function automatic bank_sel_t mode_to_bank(input logic [MODE_W-1:0] m);
      bank_sel_t r;
      r.valid = 1'b1;
      r.idx   = '0;
      case (m)
         MODE_FIQ: r.idx = 3'd0;
         MODE_IRQ: r.idx = 3'd1;
         MODE_SVC: r.idx = 3'd2;
         MODE_ABT: r.idx = 3'd3;
         MODE_UND: r.idx = 3'd4;
         default:  r.valid = 1'b0;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/psr_field_merge.sv
module psr_field_merge #(
   parameter int WIDTH  = 32,
   parameter int LANE_W = 8,
   localparam int LANES = WIDTH / LANE_W
) (
   input  logic [WIDTH-1:0] old_val,
   input  logic [WIDTH-1:0] new_val,
   input  logic [LANES-1:0] lane_en,
   output logic [WIDTH-1:0] merged
);
   if (WIDTH % LANE_W != 0) begin : g_bad_width
      $error("psr_field_merge: WIDTH must be a multiple of LANE_W");
   end

   for (genvar k = 0; k < LANES; k++) begin : g_lane
      assign merged[k*LANE_W +: LANE_W] =
         lane_en[k] ? new_val[k*LANE_W +: LANE_W] : old_val[k*LANE_W +: LANE_W];
   end
endmodule

// File: rtl/psr_bank_decode.sv
module psr_bank_decode
   import psr_pkg::*;
(
   input  logic [MODE_W-1:0]     mode,
   output logic                  has_bank,
   output logic [BANK_IDX_W-1:0] bank_idx
);
   bank_sel_t sel;
   always_comb begin
      sel      = mode_to_bank(mode);
      has_bank = sel.valid;
      bank_idx = sel.idx;
   end
endmodule

// File: rtl/psr_saved_file.sv
module psr_saved_file #(
   parameter int NUM_BANKS = 5,
   parameter int WIDTH     = 32,
   parameter int LANE_W    = 8,
   parameter int IDX_W     = 3,
   localparam int LANES    = WIDTH / LANE_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [LANES-1:0] wr_lanes,
   input  logic [WIDTH-1:0] wr_data,
   input  logic [IDX_W-1:0] rd_idx,
   output logic [WIDTH-1:0] rd_data
);
   if (NUM_BANKS > (1 << IDX_W)) begin : g_bad_idx
      $error("psr_saved_file: IDX_W too narrow for NUM_BANKS");
   end

   logic [WIDTH-1:0] bank_q [NUM_BANKS];

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      logic [WIDTH-1:0] nxt;
      psr_field_merge #(.WIDTH(WIDTH), .LANE_W(LANE_W)) u_merge (
         .old_val (bank_q[b]),
         .new_val (wr_data),
         .lane_en (wr_lanes),
         .merged  (nxt)
      );
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            bank_q[b] <= '0;
         else if (wr_en && wr_idx == IDX_W'(b))
            bank_q[b] <= nxt;
      end
   end

   always_comb begin
      rd_data = '0;
      for (int b = 0; b < NUM_BANKS; b++)
         if (rd_idx == IDX_W'(b)) rd_data = bank_q[b];
   end
endmodule

// File: rtl/psr_write_unit.sv
module psr_write_unit
   import psr_pkg::*;
#(
   parameter int NUM_BANKS = BANKS,
   localparam int LANES    = FIELDS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              wr_target,
   input  logic [LANES-1:0]  field_mask,
   input  logic [PSR_W-1:0]  wr_data,
   input  logic              mode_req,
   input  logic [MODE_W-1:0] mode_req_val,
   input  logic [MODE_W-1:0] rd_mode,
   output logic [PSR_W-1:0]  cpsr_out,
   output logic [PSR_W-1:0]  spsr_out,
   output logic [MODE_W-1:0] mode_out,
   output logic              flag_n,
   output logic              flag_z,
   output logic              flag_c,
   output logic              flag_v,
   output logic              flag_i,
   output logic              flag_f,
   output logic              flag_t,
   output logic              mode_switch,
   output logic              privileged
);
   if (NUM_BANKS != BANKS) begin : g_bad_banks
      $error("psr_write_unit: bank decode is fixed at five banks");
   end
   if (LANES != 4) begin : g_bad_lanes
      $error("psr_write_unit: four byte fields expected");
   end

   logic [PSR_W-1:0]      cpsr_q, cpsr_d, cpsr_merged;
   logic                  switch_q;
   logic                  cur_has, rd_has;
   logic [BANK_IDX_W-1:0] cur_idx, rd_idx;
   logic [LANES-1:0]      live_lanes;
   logic [PSR_W-1:0]      saved_rd;
   logic                  priv_w;
   logic                  live_wr, saved_wr;

   assign priv_w     = |cpsr_q[1:0];
   assign live_lanes = {field_mask[LANES-1], field_mask[LANES-2:0] & {(LANES-1){priv_w}}};
   assign live_wr    = wr_en && !wr_target && !mode_req;
   assign saved_wr   = wr_en &&  wr_target && !mode_req && cur_has;

   psr_bank_decode u_cur_dec (.mode(cpsr_q[MODE_W-1:0]), .has_bank(cur_has), .bank_idx(cur_idx));
   psr_bank_decode u_rd_dec  (.mode(rd_mode),            .has_bank(rd_has),  .bank_idx(rd_idx));

   psr_field_merge #(.WIDTH(PSR_W), .LANE_W(BYTE_W)) u_live_merge (
      .old_val (cpsr_q),
      .new_val (wr_data),
      .lane_en (live_lanes),
      .merged  (cpsr_merged)
   );

   psr_saved_file #(
      .NUM_BANKS (NUM_BANKS),
      .WIDTH     (PSR_W),
      .LANE_W    (BYTE_W),
      .IDX_W     (BANK_IDX_W)
   ) u_saved (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (saved_wr),
      .wr_idx   (cur_idx),
      .wr_lanes (field_mask),
      .wr_data  (wr_data),
      .rd_idx   (rd_idx),
      .rd_data  (saved_rd)
   );

   always_comb begin
      cpsr_d = cpsr_q;
      if (mode_req)
         cpsr_d = {cpsr_q[PSR_W-1:MODE_W], mode_req_val};
      else if (live_wr)
         cpsr_d = cpsr_merged;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cpsr_q   <= PSR_RESET;
         switch_q <= 1'b0;
      end else begin
         cpsr_q   <= cpsr_d;
         switch_q <= (cpsr_d[MODE_W-1:0] != cpsr_q[MODE_W-1:0]);
      end
   end

   assign cpsr_out    = cpsr_q;
   assign spsr_out    = rd_has ? saved_rd : cpsr_q;
   assign mode_out    = cpsr_q[MODE_W-1:0];
   assign flag_n      = cpsr_q[31];
   assign flag_z      = cpsr_q[30];
   assign flag_c      = cpsr_q[29];
   assign flag_v      = cpsr_q[28];
   assign flag_i      = cpsr_q[7];
   assign flag_f      = cpsr_q[6];
   assign flag_t      = cpsr_q[5];
   assign mode_switch = switch_q;
   assign privileged  = priv_w;
endmodule

// File: rtl/psr_write_unit_chk.sv
module psr_write_unit_chk
   import psr_pkg::*;
(
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic              wr_target,
   input logic              mode_req,
   input logic [MODE_W-1:0] mode_req_val,
   input logic [PSR_W-1:0]  cpsr_out,
   input logic [MODE_W-1:0] mode_out,
   input logic              mode_switch
);
   a_r3_user_low_bytes_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_target && !mode_req && mode_out[1:0] == 2'b00)
      |=> cpsr_out[23:0] == $past(cpsr_out[23:0]));

   a_r4_saved_write_live_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_target && !mode_req) |=> cpsr_out == $past(cpsr_out));

   a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en && !mode_req) |=> $stable(cpsr_out));

   a_r10_mode_req_lands: assert property (@(posedge clk) disable iff (!rst_n)
      mode_req |=> mode_out == $past(mode_req_val));

   a_r8_pulse_means_change: assert property (@(posedge clk) disable iff (!rst_n)
      mode_switch |-> mode_out != $past(mode_out));

   a_r8_change_means_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_out != $past(mode_out)) |-> mode_switch);
endmodule

bind psr_write_unit psr_write_unit_chk u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .wr_en        (wr_en),
   .wr_target    (wr_target),
   .mode_req     (mode_req),
   .mode_req_val (mode_req_val),
   .cpsr_out     (cpsr_out),
   .mode_out     (mode_out),
   .mode_switch  (mode_switch)
);

// File: tb/psr_write_unit_tb.sv
module psr_write_unit_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0, wr_target = 1'b0, mode_req = 1'b0;
   logic [3:0]  field_mask = '0;
   logic [31:0] wr_data = '0;
   logic [4:0]  mode_req_val = '0, rd_mode = '0;
   logic [31:0] cpsr_out, spsr_out;
   logic [4:0]  mode_out;
   logic        flag_n, flag_z, flag_c, flag_v, flag_i, flag_f, flag_t;
   logic        mode_switch, privileged;

   int checks = 0, errors = 0;
   logic [31:0] exp_cpsr;
   logic [31:0] exp_saved [5];
   logic        exp_sw;

   always #5 clk = ~clk;

   psr_write_unit u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_target(wr_target),
      .field_mask(field_mask), .wr_data(wr_data), .mode_req(mode_req),
      .mode_req_val(mode_req_val), .rd_mode(rd_mode), .cpsr_out(cpsr_out),
      .spsr_out(spsr_out), .mode_out(mode_out), .flag_n(flag_n), .flag_z(flag_z),
      .flag_c(flag_c), .flag_v(flag_v), .flag_i(flag_i), .flag_f(flag_f),
      .flag_t(flag_t), .mode_switch(mode_switch), .privileged(privileged)
   );

   function automatic int bank_of(input logic [4:0] m);
      case (m)
         5'b10001: return 0;
         5'b10010: return 1;
         5'b10011: return 2;
         5'b10111: return 3;
         5'b11011: return 4;
         default:  return -1;
      endcase
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic check_outputs(input string tag);
      chk({"R2/R3 cpsr ", tag}, cpsr_out, exp_cpsr);
      chk("R7 mode", {27'd0, mode_out}, {27'd0, exp_cpsr[4:0]});
      chk("R7 flags", {25'd0, flag_n, flag_z, flag_c, flag_v, flag_i, flag_f, flag_t},
          {25'd0, exp_cpsr[31], exp_cpsr[30], exp_cpsr[29], exp_cpsr[28],
           exp_cpsr[7], exp_cpsr[6], exp_cpsr[5]});
      chk("R9 privileged", {31'd0, privileged}, {31'd0, exp_cpsr[1] | exp_cpsr[0]});
      chk("R8 mode_switch", {31'd0, mode_switch}, {31'd0, exp_sw});
   endtask

   task automatic check_reads(input string req);
      logic [4:0] rl [8] = '{5'b10000, 5'b10001, 5'b10010, 5'b10011,
                             5'b10111, 5'b11011, 5'b11111, 5'b00101};
      for (int r = 0; r < 8; r++) begin
         int b;
         rd_mode = rl[r];
         #1;
         b = bank_of(rl[r]);
         chk(req, spsr_out, (b >= 0) ? exp_saved[b] : exp_cpsr);
      end
   endtask

   // One accepted request, then the model update and the output checks.
   task automatic step(input logic we, input logic tgt, input logic [3:0] msk,
                       input logic [31:0] d, input logic mr, input logic [4:0] mv,
                       input string tag);
      logic [4:0] old_mode;
      int b;
      wr_en = we; wr_target = tgt; field_mask = msk; wr_data = d;
      mode_req = mr; mode_req_val = mv;
      @(posedge clk);
      @(negedge clk);
      wr_en = 1'b0; mode_req = 1'b0;
      old_mode = exp_cpsr[4:0];
      if (mr) begin
         exp_cpsr[4:0] = mv;                     // R10
      end else if (we && !tgt) begin
         for (int k = 0; k < 4; k++)
            if (msk[k] && (k == 3 || old_mode[1:0] != 2'b00))
               exp_cpsr[k*8 +: 8] = d[k*8 +: 8];
      end else if (we && tgt) begin
         b = bank_of(old_mode);
         if (b >= 0)
            for (int k = 0; k < 4; k++)
               if (msk[k]) exp_saved[b][k*8 +: 8] = d[k*8 +: 8];
      end
      exp_sw = (exp_cpsr[4:0] != old_mode);
      check_outputs(tag);
   endtask

   task automatic idle(input string tag);
      @(posedge clk);
      @(negedge clk);
      exp_sw = 1'b0;
      check_outputs(tag);
   endtask

   initial begin
      logic [4:0] ml [7] = '{5'b10000, 5'b10001, 5'b10010, 5'b10011,
                             5'b10111, 5'b11011, 5'b11111};
      exp_cpsr = 32'h0000_00D3;
      for (int b = 0; b < 5; b++) exp_saved[b] = '0;
      exp_sw = 1'b0;
      repeat (3) @(negedge clk);
      check_outputs("R1 reset");
      check_reads("R1 saved reset");
      rst_n = 1'b1;
      @(negedge clk);
      check_outputs("R1 after release");

      for (int m = 0; m < 7; m++) begin
         step(1'b0, 1'b0, 4'h0, 32'h0, 1'b1, ml[m], "R10 enter mode");
         idle("R8 pulse clears");
         for (int k = 0; k < 16; k++) begin
            logic [31:0] d;
            d = (32'h9E37_79B9 * (k + 1)) ^ (32'h0101_0101 * m);
            d[4:0] = ml[m];
            step(1'b1, 1'b0, 4'(k), d, 1'b0, 5'd0, "R2/R3 live sweep");
            d = ~d ^ (32'h0F1E_2D3C * k);
            step(1'b1, 1'b1, 4'(k), d, 1'b0, 5'd0, "R4/R5 saved sweep");
         end
         check_reads("R4/R5/R6 readback");
      end

      // R10: mode_req wins over a concurrent live write that would change the mode
      step(1'b0, 1'b0, 4'h0, 32'h0, 1'b1, 5'b10011, "R10 to svc");
      idle("R8 clear");
      step(1'b1, 1'b0, 4'hF, 32'hFFFF_FF17, 1'b1, 5'b10010, "R10 priority");
      check_reads("R10 no saved effect");
      step(1'b1, 1'b1, 4'hF, 32'h1234_5678, 1'b1, 5'b10010, "R10 cancels saved");
      check_reads("R10 saved cancelled");
      // R8: live write that changes the mode in a privileged mode, then one that keeps it
      step(1'b1, 1'b0, 4'h1, 32'h0000_0011, 1'b0, 5'd0, "R8 write changes mode");
      step(1'b1, 1'b0, 4'h1, 32'h0000_00F1, 1'b0, 5'd0, "R8 same mode no pulse");
      // R3: user mode cannot escape through a control byte write
      step(1'b0, 1'b0, 4'h0, 32'h0, 1'b1, 5'b10000, "R10 to user");
      step(1'b1, 1'b0, 4'hF, 32'hA000_00D3, 1'b0, 5'd0, "R3 user full mask");
      idle("R11 hold");
      check_reads("R6 fallback");

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #1_000_000;
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule